// File: doc/BRIEF.md
# Self-Correcting Twisted-Ring Phase Sequencer

This block is a six-bit twisted-ring (Johnson) counter used as a one-of-twelve phase sequencer. On every enabled clock it shifts its register left by one place and feeds the inverted top bit into the bottom. It therefore walks a fixed loop of twelve states. Only one register bit changes per step. Twelve phase strobes are each decoded from one pair of neighbouring register bits. Because of this, a strobe cannot spike while the counter moves between two legal states.

The other 52 patterns of the register are not part of the loop. If the register lands in one of them, for example through an upset, plain shifting would keep it in loops of unused patterns for ever. The block examines the register every cycle, whether or not the enable is high. A pattern is recognised as unused when more than one neighbouring bit pair differs. On that clock the register is reloaded with all zeros and a fault flag is set. The flag stays set until reset. No legal pattern ever triggers this path.

Top module: `jsq_sequencer`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, the block clears `count_o` to 000000 and `fault_o` to 0 after that edge. In that state `phase_o` equals 12'h001.
- R2: From a legal state with `en` high, each rising edge loads `{count_o[4:0], ~count_o[5]}`. Starting at 000000, this visits 000001, 000011, 000111, 001111, 011111, 111111, 111110, 111100, 111000, 110000, 100000, and then returns to 000000.
- R3: From a legal state with `en` low, `count_o` keeps its value across the clock edge.
- R4: Every enabled step between legal states changes exactly one bit of `count_o`.
- R5: In the legal state with sequence index k (000000 is index 0, in the order given in R2), `phase_o` has bit k high and every other bit low. Each bit is the AND of two neighbouring register bits, one of them taken inverted where needed.
- R6: When `count_o` holds any of the 52 patterns outside the R2 loop, `count_o` is 000000 after the next rising edge. This holds whether `en` is high or low.
- R7: The edge that recovers an unused pattern sets `fault_o`. It then stays at 1 on every later edge until reset.
- R8: A legal pattern never causes recovery and never sets `fault_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Advance the ring when high, hold when low |
| count_o | output | 6 | Raw ring register |
| phase_o | output | 12 | One-hot phase strobes decoded from neighbouring bit pairs |
| fault_o | output | 1 | Sticky flag: an unused pattern was seen and recovered |

## Verification
The ring state and the fault flag are both registered. Each result is therefore due one rising edge after the stimulus that causes it: an enable level, a reset, or a pattern forced into the register. The phase strobes are pure decodes of the register, so they change in the same cycle as `count_o`. The bench applies every stimulus just after a falling edge. It samples all three outputs at the following falling edge, which is half a period after the edge that is due to update them. Each injected pattern first passes through one reset cycle. Right after that cycle the bench loads all 64 patterns, with the enable both high and low, and expects either a normal step or a return to 000000 with the flag set.

// File: rtl/jsq_pkg.sv
// Shared sizing for the twisted-ring phase sequencer.
// Assumes a ring of at least two bits; the phase count follows from it.
package jsq_pkg;
    localparam int unsigned JSQ_RING_W  = 6;
    localparam int unsigned JSQ_PHASE_N = 2 * JSQ_RING_W;
endpackage

// File: rtl/jsq_trap.sv
// Unused-pattern detector for a twisted ring.
// Legal patterns hold at most one boundary between a run of ones and a
// run of zeros, so two or more differing neighbour pairs mark a pattern
// outside the loop. This flags every unused pattern, so every parasitic
// cycle is caught, and it never flags a legal pattern.
// Assumes W >= 2.
module jsq_trap #(
    parameter int unsigned W = 6
) (
    input  logic [W-1:0] ring_i,
    output logic         stray_o
);
    logic [W-2:0] edge_diff;

    // Mark each neighbour pair whose two bits differ.
    always_comb edge_diff = ring_i[W-2:0] ^ ring_i[W-1:1];

    // More than one boundary means the pattern is not in the loop.
    always_comb stray_o = ($countones(edge_diff) > 1);
endmodule

// File: rtl/jsq_next.sv
// Next-state selection for the ring register.
// Recovery to all zeros takes priority over both stepping and holding.
// This way a trapped pattern is cleared even while the ring is stalled.
module jsq_next #(
    parameter int unsigned W = 6
) (
    input  logic [W-1:0] ring_i,
    input  logic         en_i,
    input  logic         stray_i,
    output logic [W-1:0] next_o
);
    // Pick recovery, a twisted shift, or hold.
    always_comb begin
        if (stray_i)
            next_o = '0;
        else if (en_i)
            next_o = {ring_i[W-2:0], ~ring_i[W-1]};
        else
            next_o = ring_i;
    end
endmodule

// File: rtl/jsq_phase.sv
// Phase strobe decoder for a twisted ring of W bits, giving 2*W strobes.
// Every strobe is a two-input AND of neighbouring (or end) bits. Only one
// ring bit moves per legal step, so no strobe can spike.
// The outputs are defined only for legal patterns.
module jsq_phase #(
    parameter int unsigned W = 6
) (
    input  logic [W-1:0]   ring_i,
    output logic [2*W-1:0] phase_o
);
    // Strobes for the all-zeros and all-ones states use the two end bits.
    always_comb begin
        phase_o[0] = ~ring_i[W-1] & ~ring_i[0];
        phase_o[W] =  ring_i[W-1] &  ring_i[0];
    end

    // Strobes for the ones front (filling) and zeros front (draining).
    for (genvar k = 1; k < W; k++) begin : g_pair
        always_comb begin
            phase_o[k]     =  ring_i[k-1] & ~ring_i[k];
            phase_o[W + k] = ~ring_i[k-1] &  ring_i[k];
        end
    end
endmodule

// File: rtl/jsq_sequencer.sv
// Self-correcting twisted-ring phase sequencer (top).
// Holds the ring register and the sticky fault flag. Stepping, trapping
// and decoding are done by the submodules. Reset is synchronous and
// active low. The inputs are assumed to be synchronous to clk.
module jsq_sequencer
    import jsq_pkg::*;
#(
    parameter int unsigned W = JSQ_RING_W,
    localparam int unsigned PN = 2 * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    output logic [W-1:0]  count_o,
    output logic [PN-1:0] phase_o,
    output logic          fault_o
);
    logic [W-1:0] ring_q;
    logic [W-1:0] ring_d;
    logic         stray;
    logic         fault_q;

    jsq_trap #(.W(W)) u_trap (
        .ring_i  (ring_q),
        .stray_o (stray)
    );

    jsq_next #(.W(W)) u_next (
        .ring_i  (ring_q),
        .en_i    (en),
        .stray_i (stray),
        .next_o  (ring_d)
    );

    jsq_phase #(.W(W)) u_phase (
        .ring_i  (ring_q),
        .phase_o (phase_o)
    );

    // Ring register: clear on reset, otherwise take the selected next state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ring_q <= '0;
        else
            ring_q <= ring_d;
    end

    // Fault flag: set on any trapped pattern, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fault_q <= 1'b0;
        else
            fault_q <= fault_q | stray;
    end

    // Drive the outputs from the registers.
    always_comb begin
        count_o = ring_q;
        fault_o = fault_q;
    end
endmodule

// File: rtl/jsq_sequencer_chk.sv
// Property checker for jsq_sequencer, attached to it with bind.
// It judges legality with its own test (the value is a run of ones filling
// from one end). It watches only the ports.
module jsq_sequencer_chk #(
    parameter int unsigned W = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           en,
    input logic [W-1:0]   count_o,
    input logic [2*W-1:0] phase_o,
    input logic           fault_o
);
    function automatic logic in_loop(input logic [W-1:0] c);
        logic         hit;
        logic [W-1:0] m;
        hit = 1'b0;
        for (int k = 0; k <= int'(W); k++) begin
            m = W'((64'd1 << k) - 64'd1);
            if (c == m || c == ~m) hit = 1'b1;
        end
        return hit;
    endfunction

    // R1: the flag is clear on the edge after reset.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> !fault_o);

    // R2: an enabled legal state steps by the twisted shift.
    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_loop(count_o) && en) |=> count_o == {$past(count_o[W-2:0]), ~$past(count_o[W-1])});

    // R3: a stalled legal state holds.
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_loop(count_o) && !en) |=> $stable(count_o));

    // R4: one bit moves per enabled legal step.
    assert_one_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_loop(count_o) && en) |=> $countones(count_o ^ $past(count_o)) == 1);

    // R5: exactly one strobe in any legal state.
    assert_phase_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_loop(count_o) |-> $countones(phase_o) == 1);

    // R6: an unused pattern returns to zero on the next edge.
    assert_recover_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_loop(count_o) |=> count_o == '0);

    // R7: recovery sets the flag.
    assert_fault_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_loop(count_o) |=> fault_o);

    // R7: the flag is sticky.
    assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> fault_o);

    // R8: a clear flag stays clear while the state is legal.
    assert_no_false_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_loop(count_o) && !fault_o) |=> !fault_o);
endmodule

bind jsq_sequencer jsq_sequencer_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .count_o (count_o),
    .phase_o (phase_o),
    .fault_o (fault_o)
);

// File: tb/jsq_sequencer_tb.sv
// Bench for jsq_sequencer. The stimulus is a seeded random enable pattern,
// plus injection of all 64 register patterns. Expected values come from
// bench functions that follow the requirements.
module jsq_sequencer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [5:0]  count_o;
    logic [11:0] phase_o;
    logic        fault_o;

    int checks = 0;
    int fails = 0;
    logic [5:0] seq [12];

    jsq_sequencer u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .count_o (count_o),
        .phase_o (phase_o),
        .fault_o (fault_o)
    );

    always #2 clk = ~clk;

    function automatic logic [5:0] twist(input logic [5:0] v);
        return {v[4:0], ~v[5]};
    endfunction

    function automatic int seq_index(input logic [5:0] v);
        for (int i = 0; i < 12; i++)
            if (seq[i] == v) return i;
        return -1;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Reset for one edge, then load pattern v with enable e on release.
    task automatic inject(input logic [5:0] v, input logic e);
        @(negedge clk);
        rst_n = 1'b0;
        en = e;
        @(negedge clk);
        rst_n = 1'b1;
        force u_dut.ring_q = v;
        #1;
        release u_dut.ring_q;
    endtask

    initial begin
        #(400000 * 4);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [5:0] exp_c;
        logic       exp_f;
        int         idx;
        void'($urandom(32'd2024));
        seq[0] = 6'b0;
        for (int i = 1; i < 12; i++) seq[i] = twist(seq[i-1]);

        // R1: reset state
        repeat (3) @(negedge clk);
        check(count_o == 6'b0, "R1 count", 32'(count_o), 0);
        check(fault_o == 1'b0, "R1 fault", 32'(fault_o), 0);
        check(phase_o == 12'h001, "R1 phase", 32'(phase_o), 32'h1);
        rst_n = 1'b1;

        // R2/R3/R4/R5: random enable walk checked against the model
        exp_c = 6'b0;
        for (int n = 0; n < 3000; n++) begin
            logic [5:0] prev;
            en = ($urandom % 4) != 0;
            prev = exp_c;
            exp_c = en ? twist(exp_c) : exp_c;
            @(negedge clk);
            idx = seq_index(exp_c);
            if (en) begin
                check(count_o == exp_c, "R2 step", 32'(count_o), 32'(exp_c));
                check($countones(count_o ^ prev) == 1, "R4 one bit", 32'(count_o ^ prev), 0);
            end else begin
                check(count_o == exp_c, "R3 hold", 32'(count_o), 32'(exp_c));
            end
            check(phase_o == (12'h001 << idx), "R5 phase", 32'(phase_o), 32'(12'h001 << idx));
            check(fault_o == 1'b0, "R8 no fault in walk", 32'(fault_o), 0);
        end

        // Full loop closure after 12 enabled steps from reset (R2)
        @(negedge clk);
        rst_n = 1'b0;
        en = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (12) @(negedge clk);
        check(count_o == 6'b0, "R2 loop closes", 32'(count_o), 0);

        // R6/R7/R8: every pattern, enable both high and low
        for (int v = 0; v < 64; v++) begin
            for (int e = 0; e < 2; e++) begin
                inject(6'(v), 1'(e));
                idx = seq_index(6'(v));
                if (idx < 0) begin
                    exp_c = 6'b0;
                    exp_f = 1'b1;
                end else begin
                    exp_c = (e != 0) ? twist(6'(v)) : 6'(v);
                    exp_f = 1'b0;
                end
                @(negedge clk);
                if (idx < 0) begin
                    check(count_o == exp_c, "R6 recover", 32'(count_o), 32'(exp_c));
                    check(fault_o == exp_f, "R7 fault set", 32'(fault_o), 32'(exp_f));
                end else begin
                    check(count_o == exp_c, "R8 legal untouched", 32'(count_o), 32'(exp_c));
                    check(fault_o == exp_f, "R8 no fault", 32'(fault_o), 32'(exp_f));
                end
                if (idx < 0 && v % 7 == 0) begin
                    // R7: sticky across further cycles, ring resumes from zero
                    exp_c = 6'b0;
                    for (int s = 0; s < 5; s++) begin
                        en = ($urandom % 2) != 0;
                        exp_c = en ? twist(exp_c) : exp_c;
                        @(negedge clk);
                        check(fault_o == 1'b1, "R7 sticky", 32'(fault_o), 1);
                        check(count_o == exp_c, "R6 resumes", 32'(count_o), 32'(exp_c));
                    end
                end
            end
        end

        // R7: reset clears the flag
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(fault_o == 1'b0, "R7 reset clears", 32'(fault_o), 0);
        rst_n = 1'b1;
        finish_run();
    end
endmodule